// File: doc/BRIEF.md
# Interval Timer with Sticky Wrap Flag and Start/Stop Free-Running Mode

This block is a small memory-mapped timer for a processor subsystem. An external tick strobe, one pulse every 500 ns, drives it. In limit mode the counter advances on each tick and returns to zero when it reaches a programmable limit. On that wrap it sets a sticky flag and raises a level interrupt. Software acknowledges the interrupt by reading the limit word. That read also restarts the count.

Setting one mode bit turns the same counter flops into a wide free-running counter with the interrupt held low. Software can pause and resume this counter through a run-control word without losing the accumulated value. The value is split across two read words.

An instance can be built as a fixed system timer, which stays in limit mode permanently.

Top module: `lim_timer`

## Requirements
- R1: The count is held at bit position CNT_LSB (default 9) and up. Each tick adds one unit there, and bits CNT_LSB-1..0 of every count read are zero.
- R2: In limit mode, reading word 1 returns the reached flag in bit 31 and the count in bits 30..CNT_LSB. The flag stays set across later ticks and word 1 reads until word 0 is read.
- R3: A limit write of zero stores 0x7FFFFFFF. A non-zero write stores bits 30..0 and drops bit 31. The limit reads 0 after reset, and this reset value counts as the maximum.
- R4: Writing word 0 sets the limit and returns the count to zero. Writing word 2 sets the limit and leaves the count unchanged.
- R5: In limit mode, a tick wraps the count to zero when count+1 is greater than or equal to limit bits 30..CNT_LSB. On that tick the reached flag and the irq output both go high.
- R6: In limit mode, reading word 0 returns the limit. That read also clears the reached flag, drops irq and restarts the count from zero.
- R7: Read data appears on rd_data on the clock edge after rd_en. The address uses bits 4..2 as the word index, and bits 1..0 are ignored.
- R8: In user mode the count does not wrap at the limit and irq stays low. The full count value is the tick count shifted left by CNT_LSB. Word 1 returns its low 32 bits, and word 0 returns its upper bits with bit 31 zero. Neither read changes the count.
- R9: In user mode, writing word 3 with bit 0 = 1 stops the count and bit 0 = 0 resumes it, keeping the accumulated value. The write is ignored in limit mode. Reading word 3 returns the stopped bit in bit 0.
- R10: Word 4 bit 0 selects user mode (1) or limit mode (0), and reads back the same way. With SYS_FIXED=1, mode writes are ignored and word 4 reads 0.
- R11: After reset the limit reads 0 and the count is 0. The reached flag and irq are low, the user counter is stopped, and the mode is limit mode.
- R12: Words 5, 6 and 7 read as zero. Writes to them change no other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle pulse per 500 ns count step |
| addr | input | 5 | Byte address; bits 4..2 select the word |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe (word 0 read in limit mode has side effects) |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, limit mode only |

## Verification
The upper user-mode word is the hardest state to reach from the ports. With the default bit position it changes only after 2^23 ticks, which is far beyond any directed run. The bench therefore runs a second instance with CNT_LSB=24 on the same bus, so that a few hundred ticks carry into the upper word. A second hard case is a limit lowered with word 2 below a count already in flight, and a return to limit mode with a user count far above the limit. Both are reached by ordering the writes so that the next tick must take the greater-or-equal wrap.

// File: rtl/lim_timer_pkg.sv
// Shared constants and helpers for the interval timer.
// Assumes a 32-bit data bus and a 31-bit limit register.
package lim_timer_pkg;

    localparam int DATA_W = 32;
    localparam int LIM_W  = 31;

    localparam logic [2:0] WRD_LIMIT  = 3'd0;
    localparam logic [2:0] WRD_COUNT  = 3'd1;
    localparam logic [2:0] WRD_LIMKEEP = 3'd2;
    localparam logic [2:0] WRD_RUN    = 3'd3;
    localparam logic [2:0] WRD_MODE   = 3'd4;

    localparam logic [LIM_W-1:0] LIM_MAX = '1;

    // A zero write means "largest limit"; otherwise bit 31 is dropped.
    function automatic logic [LIM_W-1:0] norm_limit(input logic [DATA_W-1:0] v);
        return (v == '0) ? LIM_MAX : v[LIM_W-1:0];
    endfunction

endpackage

// File: rtl/lim_timer_ctrl.sv
// Control registers: limit, run/stop and mode.
// Assumes write strobes are already decoded by the parent. With SYS_FIXED
// set, the mode is tied to limit mode and mode writes are dropped.
module lim_timer_ctrl
    import lim_timer_pkg::*;
#(
    parameter bit SYS_FIXED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lim,
    input  logic              wr_run,
    input  logic              wr_mode,
    input  logic [DATA_W-1:0] wdata,
    output logic [LIM_W-1:0]  limit_q,
    output logic              user_q,
    output logic              stopped_q
);

    // Limit register, normalised on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)       limit_q <= '0;
        else if (wr_lim)  limit_q <= norm_limit(wdata);
    end

    // Run/stop bit, honoured only in user mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                stopped_q <= 1'b1;
        else if (wr_run && user_q) stopped_q <= wdata[0];
    end

    generate
        if (SYS_FIXED) begin : g_fixed
            assign user_q = 1'b0;
        end else begin : g_switch
            // Mode bit for a switchable instance.
            always_ff @(posedge clk) begin
                if (!rst_n)       user_q <= 1'b0;
                else if (wr_mode) user_q <= wdata[0];
            end

            a_r10_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
                wr_mode |=> user_q == $past(wdata[0]));
        end
    endgenerate

    a_r3_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lim && wdata == '0) |=> limit_q == LIM_MAX);

    a_r9_run_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_run && !user_q) |=> $stable(stopped_q));

endmodule

// File: rtl/lim_timer_core.sv
// Shared counter: wraps at the limit field in limit mode, free-runs with
// start/stop in user mode. Holds the sticky reached flag.
// Assumes restart has priority over a tick in the same cycle.
module lim_timer_core #(
    parameter int CNT_LSB = 9,
    parameter int TOT_W   = 54
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       restart,
    input  logic                       ack,
    input  logic                       user,
    input  logic                       stopped,
    input  logic [30-CNT_LSB:0]        lim_field,
    output logic [TOT_W-CNT_LSB-1:0]   cnt,
    output logic                       reached
);

    localparam int LF_W = 31 - CNT_LSB;
    localparam int U_W  = TOT_W - CNT_LSB;

    logic [U_W:0] nxt;
    logic [U_W:0] lim_ext;
    logic         wrap;

    assign nxt     = {1'b0, cnt} + 1'b1;
    assign lim_ext = {{(U_W + 1 - LF_W){1'b0}}, lim_field};
    assign wrap    = !user && tick && !restart && (nxt >= lim_ext);

    // Counter: restart, wrap at limit, or advance when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= '0;
        else if (restart || wrap)            cnt <= '0;
        else if (tick && (!user || !stopped)) cnt <= nxt[U_W-1:0];
    end

    // Sticky reached flag: set on wrap, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)     reached <= 1'b0;
        else if (ack)   reached <= 1'b0;
        else if (wrap)  reached <= 1'b1;
    end

    a_r2_reached_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (reached && !ack) |=> reached);

    a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cnt == '0);

    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!user && $rose(reached)) |-> cnt == '0);

    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(cnt));

    a_r9_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (user && stopped && !restart) |=> $stable(cnt));

endmodule

// File: rtl/lim_timer_rdmux.sv
// Read word selection for the interval timer.
// Assumes the count field layout depends only on CNT_LSB and TOT_W.
module lim_timer_rdmux
    import lim_timer_pkg::*;
#(
    parameter int CNT_LSB = 9,
    parameter int TOT_W   = 54
) (
    input  logic [2:0]               word,
    input  logic                     user,
    input  logic                     reached,
    input  logic                     stopped,
    input  logic [LIM_W-1:0]         limit_q,
    input  logic [TOT_W-CNT_LSB-1:0] cnt,
    output logic [DATA_W-1:0]        value
);

    localparam int U_W  = TOT_W - CNT_LSB;
    localparam int LF_W = 31 - CNT_LSB;
    localparam int LO_T = 32 - CNT_LSB;
    localparam int HI_W = U_W - LO_T;

    logic [DATA_W-1:0] lim_word, cnt_word, lo_word, hi_word;

    assign lim_word = {1'b0, limit_q};
    assign cnt_word = {reached, cnt[LF_W-1:0], {CNT_LSB{1'b0}}};
    assign lo_word  = {cnt[LO_T-1:0], {CNT_LSB{1'b0}}};
    assign hi_word  = {{(DATA_W - HI_W){1'b0}}, cnt[U_W-1:LO_T]};

    // Select the word for the addressed slot and current mode.
    always_comb begin
        case (word)
            WRD_LIMIT: value = user ? hi_word : lim_word;
            WRD_COUNT: value = user ? lo_word : cnt_word;
            WRD_RUN:   value = {31'd0, stopped};
            WRD_MODE:  value = {31'd0, user};
            default:   value = '0;
        endcase
    end

endmodule

// File: rtl/lim_timer.sv
// Interval timer top: address decode, registered read port, irq output.
// Assumes one bus access per cycle and a tick strobe one clock wide.
module lim_timer
    import lim_timer_pkg::*;
#(
    parameter int CNT_LSB   = 9,
    parameter int TOT_W     = 54,
    parameter bit SYS_FIXED = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic [4:0]  addr,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    output logic [31:0] rd_data,
    output logic        irq
);

    localparam int U_W  = TOT_W - CNT_LSB;
    localparam int LF_W = 31 - CNT_LSB;

    logic [2:0]        word;
    logic              wr_lim, wr_run, wr_mode, ack, restart;
    logic [LIM_W-1:0]  limit_q;
    logic              user_q, stopped_q, reached;
    logic [U_W-1:0]    cnt;
    logic [LF_W-1:0]   lim_field;
    logic [DATA_W-1:0] rd_value;
    logic              unused_bits;

    assign word        = addr[4:2];
    assign unused_bits = ^addr[1:0];

    assign wr_lim  = wr_en && (word == WRD_LIMIT || word == WRD_LIMKEEP);
    assign wr_run  = wr_en && (word == WRD_RUN);
    assign wr_mode = wr_en && (word == WRD_MODE);
    assign ack     = rd_en && (word == WRD_LIMIT) && !user_q;
    assign restart = ack || (wr_en && word == WRD_LIMIT);

    assign lim_field = (limit_q == '0) ? '1 : limit_q[LIM_W-1:CNT_LSB];
    assign irq       = reached && !user_q;

    lim_timer_ctrl #(.SYS_FIXED(SYS_FIXED)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_lim(wr_lim), .wr_run(wr_run),
        .wr_mode(wr_mode), .wdata(wr_data), .limit_q(limit_q),
        .user_q(user_q), .stopped_q(stopped_q)
    );

    lim_timer_core #(.CNT_LSB(CNT_LSB), .TOT_W(TOT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart), .ack(ack),
        .user(user_q), .stopped(stopped_q), .lim_field(lim_field),
        .cnt(cnt), .reached(reached)
    );

    lim_timer_rdmux #(.CNT_LSB(CNT_LSB), .TOT_W(TOT_W)) u_rdmux (
        .word(word), .user(user_q), .reached(reached), .stopped(stopped_q),
        .limit_q(limit_q), .cnt(cnt), .value(rd_value)
    );

    // Registered read data, captured on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_value;
    end

    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (!irq && rd_data[30:0] == $past(limit_q)));

    a_r12_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && word > WRD_MODE) |=> rd_data == '0);

endmodule

// File: tb/lim_timer_tb.sv
// Directed bench: three instances share one bus (default, wide-step, fixed).
module lim_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_m, rd_a, rd_s;
    logic        irq_m, irq_a, irq_s;
    logic [31:0] v_m, v_a, v_s;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    lim_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_m), .irq(irq_m)
    );
    lim_timer #(.CNT_LSB(24)) u_wide (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_a), .irq(irq_a)
    );
    lim_timer #(.SYS_FIXED(1'b1)) u_sys (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_s), .irq(irq_s)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        v_m = rd_m; v_a = rd_a; v_s = rd_s;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R11: reset state, R7 registered read
    task automatic t_reset();
        do_reset();
        chk("R11 irq", {31'd0, irq_m}, 32'd0);
        rd(5'h04); chk("R11 count", v_m, 32'd0);
        rd(5'h0C); chk("R11 stopped", v_m, 32'd1);
        rd(5'h10); chk("R11 mode", v_m, 32'd0);
        rd(5'h00); chk("R11 limit", v_m, 32'd0);
    endtask

    // R1 step, R5 wrap, R2 sticky
    task automatic t_count_wrap();
        wr(5'h00, 32'h0000_0A00);
        ticks(3); rd(5'h04); chk("R1 step", v_m, 32'h0000_0600);
        ticks(1); chk("R5 no early irq", {31'd0, irq_m}, 32'd0);
        ticks(1); chk("R5 irq at wrap", {31'd0, irq_m}, 32'd1);
        rd(5'h04); chk("R5 wrap word", v_m, 32'h8000_0000);
        ticks(2); rd(5'h04); chk("R2 sticky", v_m, 32'h8000_0400);
    endtask

    // R6 acknowledge by limit read
    task automatic t_ack();
        rd(5'h00); chk("R6 limit value", v_m, 32'h0000_0A00);
        chk("R6 irq dropped", {31'd0, irq_m}, 32'd0);
        rd(5'h04); chk("R6 restart", v_m, 32'd0);
    endtask

    // R4 limit writes, R3 normalisation, R5 lowered limit
    task automatic t_limits();
        ticks(2);
        wr(5'h08, 32'h0000_1400);
        rd(5'h04); chk("R4 word2 keeps count", v_m, 32'h0000_0400);
        ticks(3);
        wr(5'h00, 32'h0000_1400);
        rd(5'h04); chk("R4 word0 restarts", v_m, 32'd0);
        ticks(7);
        wr(5'h08, 32'h0000_0A00);
        ticks(1); chk("R5 lowered limit wraps", {31'd0, irq_m}, 32'd1);
        rd(5'h04); chk("R5 lowered limit word", v_m, 32'h8000_0000);
        wr(5'h08, 32'h0000_0000);
        rd(5'h00); chk("R3 zero is max", v_m, 32'h7FFF_FFFF);
        wr(5'h08, 32'h8000_0A00);
        rd(5'h00); chk("R3 bit31 dropped", v_m, 32'h0000_0A00);
    endtask

    // R9 stop ignored in limit mode, R10 mode, R8 user counting
    task automatic t_user();
        wr(5'h0C, 32'd0);
        rd(5'h0C); chk("R9 ignored in limit mode", v_m, 32'd1);
        wr(5'h10, 32'd1);
        rd(5'h10); chk("R10 mode set", v_m, 32'd1);
        chk("R10 fixed ignores", v_s, 32'd0);
        wr(5'h00, 32'h0000_0A00);
        ticks(4); rd(5'h04); chk("R9 stopped holds", v_m, 32'd0);
        wr(5'h0C, 32'd0);
        rd(5'h0C); chk("R9 running", v_m, 32'd0);
        ticks(20);
        rd(5'h04); chk("R8 low word past limit", v_m, 32'h0000_2800);
        chk("R8 irq low", {31'd0, irq_m}, 32'd0);
        wr(5'h0C, 32'd1); ticks(5);
        rd(5'h04); chk("R9 stop keeps count", v_m, 32'h0000_2800);
        wr(5'h0C, 32'd0); ticks(1);
        rd(5'h04); chk("R9 resume", v_m, 32'h0000_2A00);
        ticks(300);
        rd(5'h00); chk("R8 high word", v_m, 32'd0);
        chk("R8 wide high word", v_a, 32'd1);
        rd(5'h04); chk("R8 low word", v_m, 32'h0002_8200);
        chk("R8 wide low word", v_a, 32'h4100_0000);
        chk("R8 irq low", {31'd0, irq_m}, 32'd0);
    endtask

    // R10 back to limit mode, R5 wrap from large count
    task automatic t_back();
        wr(5'h10, 32'd0);
        rd(5'h10); chk("R10 mode cleared", v_m, 32'd0);
        ticks(1); chk("R5 wrap from user count", {31'd0, irq_m}, 32'd1);
        rd(5'h00); chk("R6 ack", {31'd0, irq_m}, 32'd0);
    endtask

    // R12 spare words, R7 byte offset ignored
    task automatic t_spare();
        wr(5'h14, 32'hFFFF_FFFF);
        wr(5'h18, 32'hFFFF_FFFF);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd(5'h14); chk("R12 word5", v_m, 32'd0);
        rd(5'h18); chk("R12 word6", v_m, 32'd0);
        rd(5'h1C); chk("R12 word7", v_m, 32'd0);
        rd(5'h10); chk("R12 mode untouched", v_m, 32'd0);
        rd(5'h0F); chk("R7 offset ignored", v_m, 32'd0);
        rd(5'h03); chk("R12 limit untouched", v_m, 32'h0000_0A00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_count_wrap();
        t_ack();
        t_limits();
        t_user();
        t_back();
        t_spare();
        t_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule